// File: doc/BRIEF.md
# Configuration Bitstream Frame Checker

This block sits on a serial configuration stream and receives it one bit per cycle in which `bit_vld` is high. It splits the stream into frames. Each frame has a start marker, a kind bit, a payload of parameter width, a checksum byte and a stop field. The block checks each frame in three ways. It verifies the stop field through the next start marker. It compares the checksum byte with the byte sum of the payload. For identity frames it compares the payload with a fixed device code held in a parameter.

Each good frame produces a one-cycle `frame_ok` pulse. The payload is presented unchanged on `frame_data`. The first error that is found is recorded as a two-bit code in a status register the host can read, and `init_n` goes low. The block then stays idle and ignores the stream until one of three things happens: `rst_n` is asserted, `prog_req` is raised, or the host writes the restart bit of the control register.

Top module: `cfgchk_top`

## Requirements
- R1: A frame opens when the previous frame is over (or after reset/restart) and a bit 0 is immediately followed by a bit 1. Any number of 1s may come before that 0. After the opening pair come one kind bit (1 = identity frame, 0 = data/address frame), then PAYLOAD_BITS payload bits (first bit ends up as the MSB of `frame_data`), then 8 checksum bits (MSB first), then 8 stop bits.
- R2: The checksum byte must equal the modulo-256 sum of the payload bytes, where payload byte k is `frame_data[8k+7:8k]`. A mismatch raises error code 2'b11.
- R3: For an identity frame whose checksum is correct, a payload that differs from ID_CODE raises error code 2'b01.
- R4: When an opening pair is detected and any of the previous frame's 8 stop bits was 0, error code 2'b10 is raised.
- R5: An error becomes visible in the cycle after the clock edge that consumed the offending bit. At that point `init_n` is 0, and reading address 0 returns the code in bits [1:0] with 0 in bits [7:2]. Code 2'b00 means no error.
- R6: Only the first error is kept. While an error is held, incoming bits are ignored, the code does not change and `frame_ok` stays 0.
- R7: Any of the following clears the code to 2'b00, sets `init_n` to 1 and starts a fresh search for an opening pair with no stale stop-bit state: `rst_n` low, `prog_req` high for one cycle, or a host write to address 1 with data bit 0 set. A partial frame in progress is discarded.
- R8: A frame that passes R2 and R3 raises `frame_ok` for exactly one cycle, in the cycle after the edge that consumed its last checksum bit. During that cycle `frame_data` equals the payload and `frame_kind` equals the kind bit.
- R9: A host write to address 0, or to address 1 with data bit 0 clear, has no effect. Address 1 reads as 0.
- R10: After reset, `init_n` is 1, `frame_ok` is 0 and the status register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial configuration bit |
| prog_req | input | 1 | Restart request, high for one cycle |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 1 | Register select: 0 status, 1 control |
| host_wdata | input | 8 | Host write data; bit 0 is the restart bit |
| host_rdata | output | 8 | Read data for the register at `host_addr` |
| init_n | output | 1 | Low while an error is held |
| frame_ok | output | 1 | One-cycle pulse for a frame that passed its checks |
| frame_kind | output | 1 | Kind bit of the last frame received |
| frame_data | output | PAYLOAD_BITS | Payload of the last frame received |

## Verification
Good frames are sent with several payloads: a mixed pattern, all-ones (the byte sum wraps to 0xF8) and the identity code. These show that framing, checksum arithmetic and payload delivery agree with one another. Each of the three errors is then provoked on its own: a checksum off by one, an identity payload with one bit flipped, and a stop field holding a single 0. This confirms that each error produces its own code, and that the stop-field error appears only when the next opening pair arrives. Further streams are sent while an error is held, and a frame is cut off by a restart. These tell true stickiness and ignore-while-idle apart from a block that merely reports the latest error. Finally, each of the three exit paths is followed by a clean frame.

// File: rtl/cfgchk_pkg.sv
package cfgchk_pkg;

   typedef enum logic [2:0] {
      SQ_HUNT  = 3'd0,
      SQ_KIND  = 3'd1,
      SQ_PAYLD = 3'd2,
      SQ_CSUM  = 3'd3,
      SQ_STOP  = 3'd4
   } seq_state_t;

   typedef enum logic [1:0] {
      ERR_NONE  = 2'b00,
      ERR_ID    = 2'b01,
      ERR_ALIGN = 2'b10,
      ERR_CSUM  = 2'b11
   } err_code_t;

   localparam logic STATUS_ADDR = 1'b0;
   localparam logic CTRL_ADDR   = 1'b1;
   localparam int   CSUM_BITS   = 8;
   localparam int   STOP_BITS   = 8;

endpackage

// File: rtl/cfgchk_seq.sv
module cfgchk_seq
   import cfgchk_pkg::*;
#(
   parameter int PAYLOAD_BITS = 64,
   parameter logic [PAYLOAD_BITS-1:0] ID_CODE = '0,
   parameter int CSUM_STYLE = 0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    halt,
   input  logic                    bit_vld,
   input  logic                    bit_in,
   output logic                    ev_id,
   output logic                    ev_align,
   output logic                    ev_csum,
   output logic                    frame_ok,
   output logic                    frame_kind,
   output logic [PAYLOAD_BITS-1:0] frame_data
);

   localparam int NBYTES = PAYLOAD_BITS / 8;
   localparam int CNT_W  = (PAYLOAD_BITS > 8) ? $clog2(PAYLOAD_BITS) : 3;
   localparam logic [CNT_W-1:0] LAST_PAY  = CNT_W'(PAYLOAD_BITS - 1);
   localparam logic [CNT_W-1:0] LAST_CSUM = CNT_W'(CSUM_BITS - 1);
   localparam logic [CNT_W-1:0] LAST_STOP = CNT_W'(STOP_BITS - 1);

   generate
      if ((PAYLOAD_BITS % 8) != 0 || PAYLOAD_BITS < 8) begin : g_bad_len
         $error("PAYLOAD_BITS must be a positive multiple of 8");
      end
      if (CSUM_STYLE < 0 || CSUM_STYLE > 1) begin : g_bad_style
         $error("CSUM_STYLE must be 0 (running) or 1 (tree)");
      end
   endgenerate

   seq_state_t              state_q;
   logic [CNT_W-1:0]        cnt_q;
   logic [PAYLOAD_BITS-1:0] pay_q;
   logic [6:0]              csr_q;
   logic                    kind_q;
   logic                    prev_zero_q;
   logic                    stop_ok_q;
   logic                    ok_q;

   logic       step;
   logic       start_seen;
   logic       last_csum;
   logic [7:0] csum_byte;
   logic [7:0] sum_now;
   logic       sum_ok;
   logic       id_ok;
   logic       good;

   assign step       = bit_vld && !halt;
   assign start_seen = (state_q == SQ_HUNT) && prev_zero_q && bit_in;
   assign last_csum  = (state_q == SQ_CSUM) && (cnt_q == LAST_CSUM);
   assign csum_byte  = {csr_q, bit_in};
   assign sum_ok     = (csum_byte == sum_now);
   assign id_ok      = !kind_q || (pay_q == ID_CODE);

   assign ev_align = step && start_seen && !stop_ok_q;
   assign ev_csum  = step && last_csum && !sum_ok;
   assign ev_id    = step && last_csum && sum_ok && !id_ok;
   assign good     = step && last_csum && sum_ok && id_ok;

   generate
      if (CSUM_STYLE == 0) begin : g_csum_run
         logic [7:0] acc_q;
         always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
               acc_q <= '0;
            end else if (step && state_q == SQ_KIND) begin
               acc_q <= '0;
            end else if (step && state_q == SQ_PAYLD && cnt_q[2:0] == 3'd7) begin
               acc_q <= acc_q + {pay_q[6:0], bit_in};
            end
         end
         assign sum_now = acc_q;
      end else begin : g_csum_tree
         logic [7:0] psum [NBYTES+1];
         assign psum[0] = '0;
         for (genvar k = 0; k < NBYTES; k++) begin : g_byte
            assign psum[k+1] = psum[k] + pay_q[8*k +: 8];
         end
         assign sum_now = psum[NBYTES];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         state_q     <= SQ_HUNT;
         cnt_q       <= '0;
         csr_q       <= '0;
         prev_zero_q <= 1'b0;
         stop_ok_q   <= 1'b1;
         ok_q        <= 1'b0;
         if (!rst_n) begin
            pay_q  <= '0;
            kind_q <= 1'b0;
         end
      end else begin
         ok_q <= good;
         if (step) begin
            unique case (state_q)
               SQ_HUNT: begin
                  prev_zero_q <= !bit_in;
                  if (start_seen && stop_ok_q) state_q <= SQ_KIND;
               end
               SQ_KIND: begin
                  kind_q  <= bit_in;
                  cnt_q   <= '0;
                  state_q <= SQ_PAYLD;
               end
               SQ_PAYLD: begin
                  pay_q <= {pay_q[PAYLOAD_BITS-2:0], bit_in};
                  if (cnt_q == LAST_PAY) begin
                     cnt_q   <= '0;
                     state_q <= SQ_CSUM;
                  end else begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end
               SQ_CSUM: begin
                  csr_q <= csum_byte[6:0];
                  if (last_csum) begin
                     cnt_q     <= '0;
                     stop_ok_q <= 1'b1;
                     state_q   <= SQ_STOP;
                  end else begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end
               SQ_STOP: begin
                  stop_ok_q <= stop_ok_q & bit_in;
                  if (cnt_q == LAST_STOP) begin
                     cnt_q       <= '0;
                     prev_zero_q <= 1'b0;
                     state_q     <= SQ_HUNT;
                  end else begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end
               default: state_q <= SQ_HUNT;
            endcase
         end
      end
   end

   assign frame_ok   = ok_q;
   assign frame_kind = kind_q;
   assign frame_data = pay_q;

   assert_one_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({ev_id, ev_align, ev_csum}) <= 1);

   assert_frozen_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !clr) |=> ($stable(state_q) && $stable(cnt_q) && !ok_q));

   assert_stop_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_STOP) |-> (cnt_q <= LAST_STOP));

endmodule

// File: rtl/cfgchk_errlat.sv
module cfgchk_errlat
   import cfgchk_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      restart,
   input  logic      ev_id,
   input  logic      ev_align,
   input  logic      ev_csum,
   output err_code_t err_code,
   output logic      init_n,
   output logic      halt
);

   err_code_t err_q;
   logic      init_n_q;

   always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
         err_q    <= ERR_NONE;
         init_n_q <= 1'b1;
      end else if (err_q == ERR_NONE) begin
         if (ev_csum) begin
            err_q    <= ERR_CSUM;
            init_n_q <= 1'b0;
         end else if (ev_align) begin
            err_q    <= ERR_ALIGN;
            init_n_q <= 1'b0;
         end else if (ev_id) begin
            err_q    <= ERR_ID;
            init_n_q <= 1'b0;
         end
      end
   end

   assign err_code = err_q;
   assign init_n   = init_n_q;
   assign halt     = (err_q != ERR_NONE);

   assert_sticky_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q != ERR_NONE && !restart) |=> (err_q == $past(err_q)));

   assert_restart_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (err_q == ERR_NONE && init_n_q));

   assert_init_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q != ERR_NONE) |-> !init_n_q);

endmodule

// File: rtl/cfgchk_host.sv
module cfgchk_host
   import cfgchk_pkg::*;
#(
   parameter int RESTART_BIT = 0
) (
   input  logic       host_wr,
   input  logic       host_addr,
   input  logic [7:0] host_wdata,
   input  err_code_t  err_code,
   output logic [7:0] host_rdata,
   output logic       restart_req
);

   generate
      if (RESTART_BIT < 0 || RESTART_BIT > 7) begin : g_bad_bit
         $error("RESTART_BIT must select a bit of the 8-bit control word");
      end
   endgenerate

   logic wdata_unused;
   assign wdata_unused = ^host_wdata;

   assign restart_req = host_wr && (host_addr == CTRL_ADDR) && host_wdata[RESTART_BIT];

   always_comb begin
      host_rdata = '0;
      if (host_addr == STATUS_ADDR) host_rdata[1:0] = err_code;
   end

endmodule

// File: rtl/cfgchk_top.sv
module cfgchk_top
   import cfgchk_pkg::*;
#(
   parameter int PAYLOAD_BITS = 64,
   parameter logic [PAYLOAD_BITS-1:0] ID_CODE = 64'h3C5A_96E1_0F7B_D248,
   parameter int CSUM_STYLE = 0,
   parameter int RESTART_BIT = 0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bit_vld,
   input  logic                    bit_in,
   input  logic                    prog_req,
   input  logic                    host_wr,
   input  logic                    host_addr,
   input  logic [7:0]              host_wdata,
   output logic [7:0]              host_rdata,
   output logic                    init_n,
   output logic                    frame_ok,
   output logic                    frame_kind,
   output logic [PAYLOAD_BITS-1:0] frame_data
);

   err_code_t err_code;
   logic      halt;
   logic      restart;
   logic      host_restart;
   logic      ev_id;
   logic      ev_align;
   logic      ev_csum;

   assign restart = prog_req || host_restart;

   cfgchk_seq #(
      .PAYLOAD_BITS(PAYLOAD_BITS),
      .ID_CODE     (ID_CODE),
      .CSUM_STYLE  (CSUM_STYLE)
   ) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (restart),
      .halt      (halt),
      .bit_vld   (bit_vld),
      .bit_in    (bit_in),
      .ev_id     (ev_id),
      .ev_align  (ev_align),
      .ev_csum   (ev_csum),
      .frame_ok  (frame_ok),
      .frame_kind(frame_kind),
      .frame_data(frame_data)
   );

   cfgchk_errlat errlat_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .ev_id   (ev_id),
      .ev_align(ev_align),
      .ev_csum (ev_csum),
      .err_code(err_code),
      .init_n  (init_n),
      .halt    (halt)
   );

   cfgchk_host #(
      .RESTART_BIT(RESTART_BIT)
   ) host_i (
      .host_wr    (host_wr),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .err_code   (err_code),
      .host_rdata (host_rdata),
      .restart_req(host_restart)
   );

   assert_ok_without_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_ok |-> (err_code == ERR_NONE && init_n));

endmodule

// File: tb/cfgchk_top_tb_top.sv
module cfgchk_top_tb_top;

   localparam int PB = 64;
   localparam logic [PB-1:0] IDC = 64'h3C5A_96E1_0F7B_D248;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bit_vld = 1'b0;
   logic          bit_in = 1'b1;
   logic          prog_req = 1'b0;
   logic          host_wr = 1'b0;
   logic          host_addr = 1'b0;
   logic [7:0]    host_wdata = '0;
   logic [7:0]    host_rdata;
   logic          init_n;
   logic          frame_ok;
   logic          frame_kind;
   logic [PB-1:0] frame_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic          cap_ok;
   logic          cap_init;
   logic          cap_kind;
   logic [7:0]    cap_stat;
   logic [PB-1:0] cap_data;

   always #5 clk = ~clk;

   cfgchk_top #(.PAYLOAD_BITS(PB), .ID_CODE(IDC)) dut_i (
      .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
      .prog_req(prog_req), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .init_n(init_n),
      .frame_ok(frame_ok), .frame_kind(frame_kind), .frame_data(frame_data)
   );

   function automatic logic [7:0] bsum(input logic [PB-1:0] p);
      logic [7:0] s = '0;
      for (int k = 0; k < PB/8; k++) s = s + p[8*k +: 8];
      return s;
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk);
      bit_vld = 1'b1;
      bit_in  = b;
   endtask

   task automatic settle();
      @(negedge clk);
      bit_vld = 1'b0;
      bit_in  = 1'b1;
   endtask

   // Sends a whole frame; outputs are captured in the cycle after the last checksum bit.
   task automatic send_frame(input logic kind, input logic [PB-1:0] pay,
                             input logic [7:0] cs, input logic [7:0] stp);
      send_bit(1'b0);
      send_bit(1'b1);
      send_bit(kind);
      for (int i = PB-1; i >= 0; i--) send_bit(pay[i]);
      for (int i = 7; i >= 0; i--) send_bit(cs[i]);
      @(negedge clk);
      cap_ok   = frame_ok;
      cap_init = init_n;
      cap_kind = frame_kind;
      cap_data = frame_data;
      cap_stat = host_rdata;
      bit_vld  = 1'b1;
      bit_in   = stp[7];
      for (int i = 6; i >= 0; i--) send_bit(stp[i]);
      settle();
   endtask

   task automatic host_write(input logic a, input logic [7:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0; host_addr = 1'b0; host_wdata = '0;
   endtask

   task automatic t_reset();
      chk("R10 init_n after reset", init_n, 1);
      chk("R10 frame_ok after reset", frame_ok, 0);
      chk("R10 status after reset", host_rdata, 0);
   endtask

   task automatic t_good_data();
      logic [PB-1:0] p = 64'h0123_4567_89AB_CDEF;
      repeat (3) send_bit(1'b1);
      send_frame(1'b0, p, bsum(p), 8'hFF);
      chk("R8 frame_ok data frame", cap_ok, 1);
      chk("R8 frame_data", cap_data, p);
      chk("R1 frame_kind data", cap_kind, 0);
      chk("R8 frame_ok one cycle", frame_ok, 0);
      chk("R2 no error good data", host_rdata, 0);
   endtask

   task automatic t_good_id_and_wrap();
      logic [PB-1:0] p = '1;
      send_frame(1'b1, IDC, bsum(IDC), 8'hFF);
      chk("R3 matching identity ok", cap_ok, 1);
      chk("R1 frame_kind identity", cap_kind, 1);
      send_frame(1'b0, p, 8'hF8, 8'hFF);
      chk("R2 wrapped checksum F8 accepted", cap_ok, 1);
      chk("R2 wrapped checksum no error", cap_stat, 0);
   endtask

   task automatic t_id_mismatch_sticky();
      logic [PB-1:0] bad = IDC ^ 64'h0000_0000_0001_0000;
      logic [PB-1:0] p   = 64'hDEAD_BEEF_0BAD_F00D;
      send_frame(1'b1, bad, bsum(bad), 8'hFF);
      chk("R3 identity mismatch code", cap_stat, 8'h01);
      chk("R5 init_n low on error", cap_init, 0);
      chk("R3 no frame_ok on mismatch", cap_ok, 0);
      send_frame(1'b0, p, bsum(p) + 8'd1, 8'h00);
      send_bit(1'b0); send_bit(1'b1); settle();
      chk("R6 first error kept", host_rdata, 8'h01);
      chk("R6 no frame_ok while idle", cap_ok, 0);
      host_write(1'b0, 8'hFF);
      chk("R9 status write ignored", host_rdata, 8'h01);
      host_write(1'b1, 8'hFE);
      chk("R9 control without restart bit ignored", init_n, 0);
      host_addr = 1'b1;
      #1;
      chk("R9 control reads zero", host_rdata, 0);
      host_addr = 1'b0;
      host_write(1'b1, 8'h01);
      chk("R7 host restart clears code", host_rdata, 0);
      chk("R7 host restart raises init_n", init_n, 1);
      send_frame(1'b0, p, bsum(p), 8'hFF);
      chk("R7 frame after host restart", cap_ok, 1);
   endtask

   task automatic t_csum_err_prog();
      logic [PB-1:0] p = 64'h5555_AAAA_1234_8765;
      send_frame(1'b0, p, bsum(p) - 8'd1, 8'hFF);
      chk("R2 checksum error code", cap_stat, 8'h03);
      chk("R2 no frame_ok bad checksum", cap_ok, 0);
      @(negedge clk); prog_req = 1'b1;
      @(negedge clk); prog_req = 1'b0;
      chk("R7 prog_req clears code", host_rdata, 0);
      chk("R7 prog_req raises init_n", init_n, 1);
   endtask

   task automatic t_align();
      logic [PB-1:0] p = 64'h0F0F_F0F0_3C3C_C3C3;
      send_frame(1'b0, p, bsum(p), 8'hEF);
      chk("R4 frame itself still ok", cap_ok, 1);
      chk("R4 no error before next start", host_rdata, 0);
      send_bit(1'b0);
      send_bit(1'b1);
      settle();
      chk("R4 alignment error code", host_rdata, 8'h02);
      chk("R5 init_n low alignment", init_n, 0);
      host_write(1'b1, 8'h01);
      send_frame(1'b0, p, bsum(p), 8'hFF);
      chk("R7 no stale stop state after restart", cap_ok, 1);
   endtask

   task automatic t_midframe_and_reset();
      logic [PB-1:0] p = 64'h8001_7FFE_0000_FFFF;
      send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
      for (int i = 0; i < 10; i++) send_bit(i[0]);
      @(negedge clk); bit_vld = 1'b0; prog_req = 1'b1;
      @(negedge clk); prog_req = 1'b0;
      send_frame(1'b0, p, bsum(p), 8'hFF);
      chk("R7 partial frame discarded", cap_ok, 1);
      chk("R8 data after partial discard", cap_data, p);
      send_frame(1'b0, p, bsum(p) ^ 8'h80, 8'hFF);
      chk("R2 second checksum error", host_rdata, 8'h03);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      chk("R7 reset clears code", host_rdata, 0);
      chk("R7 reset raises init_n", init_n, 1);
      send_frame(1'b0, p, bsum(p), 8'hFF);
      chk("R7 frame after reset", cap_ok, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_good_data();
      t_good_id_and_wrap();
      t_id_mismatch_sticky();
      t_csum_err_prog();
      t_align();
      t_midframe_and_reset();
      repeat (2) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule